// File: doc/BRIEF.md
# Host Parallel Mailbox Bridge

The bridge lets a host processor with a simple asynchronous parallel bus talk to a motion-controller core through a small shared-register mailbox. The host side has an active-low chip select, read strobe and write strobe. It also has a command/data select line and a ready flag. The host data bus is 8 or 16 bits wide, fixed by the `HOST_W` parameter. With an 8-bit bus, each 16-bit word moves as two bytes, high byte first. The block assembles a written word, or splits a read word, using a byte toggle.

The controller side is synchronous to the block clock. It has an active-low strobe, a read/write line (high means the controller reads), a 2-bit register address and 16-bit data in and out. Four 16-bit registers are shared:
- address 0: the host instruction word;
- address 1: the host data word;
- address 2: the data word the controller returns to the host;
- address 3: the control/status register.

When a full host word has moved, the block drops the ready flag and raises an interrupt to the controller. Both stay that way until the controller writes address 3. A host read with the command line high returns a status word instead of data.

Top module: `host_mbox_bridge`

## Requirements
- R1: After reset, ready is high, the controller interrupt is low, and registers 0 to 2 read zero. Register 3 reads 0x8000.
- R2: In 16-bit mode, a host write (chip select low) acts when its write strobe rises. With the command line high, the word lands in register 0. With the command line low, it lands in register 1.
- R3: In 8-bit mode the first byte written is the high byte. Ready stays high after it. After the second byte, the assembled word is stored.
- R4: Each completed host word transfer (read or write) drives ready low and the controller interrupt high. In 16-bit mode every single transfer completes a word.
- R5: A host read with the command line low returns register 2. In 8-bit mode the high byte comes first and the low byte second.
- R6: A host read with the command line high returns a status word and changes neither ready nor the interrupt. The status word has ready in bit 15, the host flag in bit 14, and zeros elsewhere. In 8-bit mode the read returns the status word's high byte, so ready is in bit 7 and the flag in bit 6.
- R7: A controller write to address 3 sets ready high and clears the interrupt. Bit 14 of the written data becomes the host flag.
- R8: While ready is low, host data transfers and instruction writes are ignored, and they leave the byte toggle untouched.
- R9: In 8-bit mode, changing the command line between bytes restarts assembly at the high byte.
- R10: The controller reads with the read/write line high. A read returns the addressed register and has no side effect. A controller write with the strobe low stores into addresses 0 to 2.
- R11: Host strobes with chip select high have no effect.
- R12: Ready stays low until the controller writes address 3, however long that takes. This includes a 100 µs wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_cs_ni | input | 1 | Host chip select, active low |
| host_rd_ni | input | 1 | Host read strobe, active low |
| host_wr_ni | input | 1 | Host write strobe, active low |
| host_cmd_i | input | 1 | High: instruction/status, low: data |
| host_d_i | input | HOST_W | Host write data |
| host_d_o | output | HOST_W | Host read data |
| host_rdy_o | output | 1 | Ready flag to host |
| ctl_strobe_ni | input | 1 | Controller access strobe, active low |
| ctl_rw_i | input | 1 | Controller direction, high = read |
| ctl_addr_i | input | 2 | Shared register address |
| ctl_d_i | input | 16 | Controller write data |
| ctl_d_o | output | 16 | Controller read data |
| ctl_irq_o | output | 1 | Transfer-complete interrupt to controller |

## Verification
The assertions assume the following about the host bus:
- The host holds chip select, the command line and write data steady across each strobe's rising edge, for at least the synchronizer depth plus one clock.
- Each strobe level lasts at least three clocks.
- The host never asserts read and write strobes together.

The bench tasks keep every strobe low for three clocks and hold select, command and data four clocks past its release. Controller accesses last exactly one clock of low strobe at a falling-edge-driven boundary. The bench samples ready and the interrupt only after the whole host handshake has settled.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int WORD_W   = 16;
  localparam int RDY_BIT  = 15;
  localparam int FLAG_BIT = 14;

  typedef enum logic [1:0] {
    REG_INSTR = 2'd0,
    REG_HDATA = 2'd1,
    REG_CDATA = 2'd2,
    REG_CTRL  = 2'd3
  } mbox_addr_e;

  function automatic logic [WORD_W-1:0] status_word(input logic rdy, input logic flag);
    return {rdy, flag, {(WORD_W-2){1'b0}}};
  endfunction
endpackage

// File: rtl/mbox_sync.sv
module mbox_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/mbox_host_side.sv
module mbox_host_side #(
  parameter int HOST_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_s_ni,
  input  logic              rd_s_ni,
  input  logic              wr_s_ni,
  input  logic              cmd_s_i,
  input  logic [HOST_W-1:0] d_s_i,
  input  logic              cmd_raw_i,
  input  logic              rdy_i,
  output logic              wr_v_o,
  output logic              rd_v_o,
  output logic              wr_cmd_o,
  output logic [15:0]       word_o,
  output logic              sel_hi_o
);
  localparam bit NARROW = (HOST_W < 16);

  logic              cs_q, rd_q, wr_q, cmd_q;
  logic [HOST_W-1:0] d_q;
  logic              tog_hi, last_cmd;
  logic              ev_wr, ev_rd, is_status, xfer, first, done;

  // one delay more than the synchronizer: values seen while strobe was still low
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q <= 1'b1; rd_q <= 1'b1; wr_q <= 1'b1; cmd_q <= 1'b0; d_q <= '0;
    end else begin
      cs_q <= cs_s_ni; rd_q <= rd_s_ni; wr_q <= wr_s_ni; cmd_q <= cmd_s_i; d_q <= d_s_i;
    end
  end

  assign ev_wr     = wr_s_ni & ~wr_q & ~cs_q;
  assign ev_rd     = rd_s_ni & ~rd_q & ~cs_q;
  assign is_status = ev_rd & cmd_q;
  assign xfer      = (ev_wr | (ev_rd & ~cmd_q)) & rdy_i;
  assign first     = tog_hi | (cmd_q != last_cmd);
  assign done      = xfer & (~NARROW | ~first);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tog_hi   <= 1'b1;
      last_cmd <= 1'b0;
    end else if (is_status) begin
      tog_hi   <= 1'b1;
      last_cmd <= 1'b1;
    end else if (xfer) begin
      tog_hi   <= ~NARROW | ~first;
      last_cmd <= cmd_q;
    end
  end

  generate
    if (NARROW) begin : g_narrow
      logic [15-HOST_W:0] hold;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) hold <= '0;
        else if (xfer && ev_wr && first) hold <= d_q[15-HOST_W:0];
      end
      assign word_o = {hold, d_q};
    end else begin : g_wide
      assign word_o = d_q;
    end
  endgenerate

  assign wr_v_o   = done & ev_wr;
  assign rd_v_o   = done & ev_rd;
  assign wr_cmd_o = cmd_q;
  assign sel_hi_o = tog_hi | (cmd_raw_i != last_cmd);
endmodule

// File: rtl/mbox_ctl_side.sv
module mbox_ctl_side (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             strobe_ni,
  input  logic             rw_i,
  input  logic [1:0]       addr_i,
  input  logic [3:0][15:0] words_i,
  output logic [3:0]       we_o,
  output logic [15:0]      d_o
);
  logic strobe_q, ev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) strobe_q <= 1'b1;
    else         strobe_q <= strobe_ni;
  end

  assign ev = ~strobe_ni & strobe_q;

  for (genvar a = 0; a < 4; a++) begin : g_we
    assign we_o[a] = ev & ~rw_i & (addr_i == 2'(a));
  end

  assign d_o = words_i[addr_i];
endmodule

// File: rtl/host_mbox_bridge.sv
module host_mbox_bridge
  import mbox_pkg::*;
#(
  parameter int HOST_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_cs_ni,
  input  logic              host_rd_ni,
  input  logic              host_wr_ni,
  input  logic              host_cmd_i,
  input  logic [HOST_W-1:0] host_d_i,
  output logic [HOST_W-1:0] host_d_o,
  output logic              host_rdy_o,
  input  logic              ctl_strobe_ni,
  input  logic              ctl_rw_i,
  input  logic [1:0]        ctl_addr_i,
  input  logic [15:0]       ctl_d_i,
  output logic [15:0]       ctl_d_o,
  output logic              ctl_irq_o
);
  localparam int SYNC_W = HOST_W + 4;
  localparam logic [SYNC_W-1:0] SYNC_RST = {3'b111, 1'b0, {HOST_W{1'b0}}};

  logic [SYNC_W-1:0] sync_q;
  logic              host_wr_v, host_rd_v, host_wr_cmd, sel_hi;
  logic [15:0]       host_word;
  logic [3:0]        ctl_we;
  logic [3:0][15:0]  ctl_words;
  logic [15:0]       instr_q, hdata_q, cdata_q, status;
  logic              rdy_q, irq_q, flag_q;

  mbox_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({host_cs_ni, host_rd_ni, host_wr_ni, host_cmd_i, host_d_i}),
    .q_o   (sync_q)
  );

  mbox_host_side #(.HOST_W(HOST_W)) u_host (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cs_s_ni  (sync_q[SYNC_W-1]),
    .rd_s_ni  (sync_q[SYNC_W-2]),
    .wr_s_ni  (sync_q[SYNC_W-3]),
    .cmd_s_i  (sync_q[HOST_W]),
    .d_s_i    (sync_q[HOST_W-1:0]),
    .cmd_raw_i(host_cmd_i),
    .rdy_i    (rdy_q),
    .wr_v_o   (host_wr_v),
    .rd_v_o   (host_rd_v),
    .wr_cmd_o (host_wr_cmd),
    .word_o   (host_word),
    .sel_hi_o (sel_hi)
  );

  assign status = status_word(rdy_q, flag_q);
  assign ctl_words = {status, cdata_q, hdata_q, instr_q};

  mbox_ctl_side u_ctl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .strobe_ni(ctl_strobe_ni),
    .rw_i     (ctl_rw_i),
    .addr_i   (ctl_addr_i),
    .words_i  (ctl_words),
    .we_o     (ctl_we),
    .d_o      (ctl_d_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      instr_q <= '0; hdata_q <= '0; cdata_q <= '0;
    end else begin
      if (ctl_we[REG_INSTR]) instr_q <= ctl_d_i;
      if (ctl_we[REG_HDATA]) hdata_q <= ctl_d_i;
      if (ctl_we[REG_CDATA]) cdata_q <= ctl_d_i;
      // host word wins over a same-cycle controller write
      if (host_wr_v && host_wr_cmd)  instr_q <= host_word;
      if (host_wr_v && !host_wr_cmd) hdata_q <= host_word;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdy_q <= 1'b1; irq_q <= 1'b0; flag_q <= 1'b0;
    end else begin
      if (ctl_we[REG_CTRL]) begin
        rdy_q  <= 1'b1;
        irq_q  <= 1'b0;
        flag_q <= ctl_d_i[FLAG_BIT];
      end
      if (host_wr_v || host_rd_v) begin
        rdy_q <= 1'b0;
        irq_q <= 1'b1;
      end
    end
  end

  assign host_d_o   = host_cmd_i ? status[15 -: HOST_W]
                    : (sel_hi ? cdata_q[15 -: HOST_W] : cdata_q[HOST_W-1:0]);
  assign host_rdy_o = rdy_q;
  assign ctl_irq_o  = irq_q;
endmodule

// File: rtl/mbox_chk.sv
module mbox_chk #(
  parameter int HOST_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              host_cs_ni,
  input logic              host_cmd_i,
  input logic [HOST_W-1:0] host_d_o,
  input logic              host_rdy_o,
  input logic [1:0]        ctl_addr_i,
  input logic [15:0]       ctl_d_o,
  input logic              ctl_irq_o,
  input logic              host_wr_v,
  input logic              host_rd_v,
  input logic [3:0]        ctl_we,
  input logic [15:0]       instr_q,
  input logic [15:0]       hdata_q
);
  AST_DONE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_wr_v || host_rd_v) |=> (!host_rdy_o && ctl_irq_o)); // R4

  AST_IRQ_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ctl_irq_o) |-> $past(host_wr_v || host_rd_v)); // R4

  AST_ACK_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_we[3] && !host_wr_v && !host_rd_v) |=> (host_rdy_o && !ctl_irq_o)); // R7

  AST_READY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(host_rdy_o) |-> $past(ctl_we[3])); // R12

  AST_BUSY_NO_XFER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !host_rdy_o |-> !(host_wr_v || host_rd_v)); // R8

  AST_BUSY_REGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!host_rdy_o && !ctl_we[0] && !ctl_we[1]) |=> ($stable(instr_q) && $stable(hdata_q))); // R8

  AST_CTL_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_addr_i == 2'd3) |-> (ctl_d_o[15] == host_rdy_o && ctl_d_o[13:0] == 14'd0)); // R10

  AST_HOST_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!host_cs_ni && host_cmd_i) |-> (host_d_o[HOST_W-1] == host_rdy_o && host_d_o[HOST_W-3:0] == '0)); // R6
endmodule

bind host_mbox_bridge mbox_chk #(.HOST_W(HOST_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .host_cs_ni(host_cs_ni),
  .host_cmd_i(host_cmd_i),
  .host_d_o  (host_d_o),
  .host_rdy_o(host_rdy_o),
  .ctl_addr_i(ctl_addr_i),
  .ctl_d_o   (ctl_d_o),
  .ctl_irq_o (ctl_irq_o),
  .host_wr_v (host_wr_v),
  .host_rd_v (host_rd_v),
  .ctl_we    (ctl_we),
  .instr_q   (instr_q),
  .hdata_q   (hdata_q)
);

// File: tb/sim_host_mbox_bridge.sv
module sim_host_mbox_bridge;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        cs8_n = 1'b1, cs16_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, cmd = 1'b0;
  logic [7:0]  h8_d = '0;
  logic [15:0] h16_d = '0;
  logic [7:0]  h8_q;
  logic [15:0] h16_q;
  logic        rdy8, rdy16, irq8, irq16;
  logic        strobe_n = 1'b1, rw = 1'b1;
  logic [1:0]  addr = '0;
  logic [15:0] cd = '0, c8_q, c16_q;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  host_mbox_bridge #(.HOST_W(8)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .host_cs_ni(cs8_n), .host_rd_ni(rd_n), .host_wr_ni(wr_n),
    .host_cmd_i(cmd), .host_d_i(h8_d), .host_d_o(h8_q), .host_rdy_o(rdy8),
    .ctl_strobe_ni(strobe_n), .ctl_rw_i(rw), .ctl_addr_i(addr), .ctl_d_i(cd),
    .ctl_d_o(c8_q), .ctl_irq_o(irq8));

  host_mbox_bridge #(.HOST_W(16)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .host_cs_ni(cs16_n), .host_rd_ni(rd_n), .host_wr_ni(wr_n),
    .host_cmd_i(cmd), .host_d_i(h16_d), .host_d_o(h16_q), .host_rdy_o(rdy16),
    .ctl_strobe_ni(strobe_n), .ctl_rw_i(rw), .ctl_addr_i(addr), .ctl_d_i(cd),
    .ctl_d_o(c16_q), .ctl_irq_o(irq16));

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // sel: 0 none, 1 = 8-bit unit, 2 = 16-bit unit
  task automatic host_wr(input int sel, input logic c, input logic [15:0] v);
    @(negedge clk);
    cmd = c; h8_d = v[7:0]; h16_d = v; cs8_n = (sel != 1); cs16_n = (sel != 2);
    @(negedge clk); wr_n = 1'b0;
    repeat (3) @(negedge clk);
    wr_n = 1'b1;
    repeat (4) @(negedge clk);
    cs8_n = 1'b1; cs16_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic host_rd(input int sel, input logic c, output logic [15:0] v);
    @(negedge clk);
    cmd = c; cs8_n = (sel != 1); cs16_n = (sel != 2);
    @(negedge clk); rd_n = 1'b0;
    repeat (3) @(negedge clk);
    v = (sel == 1) ? {8'h00, h8_q} : h16_q;
    rd_n = 1'b1;
    repeat (4) @(negedge clk);
    cs8_n = 1'b1; cs16_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic ctl_wr(input logic [1:0] a, input logic [15:0] v);
    @(negedge clk);
    addr = a; cd = v; rw = 1'b0; strobe_n = 1'b0;
    @(negedge clk);
    strobe_n = 1'b1; rw = 1'b1;
  endtask

  task automatic ctl_rd(input logic [1:0] a, output logic [15:0] v8, output logic [15:0] v16);
    @(negedge clk);
    addr = a; rw = 1'b1; strobe_n = 1'b0;
    #1;
    v8 = c8_q; v16 = c16_q;
    @(negedge clk);
    strobe_n = 1'b1;
  endtask

  initial begin
    logic [15:0] v, a8, a16, w, e_i8, e_h8, e_i16, e_h16;
    e_i8 = '0; e_h8 = '0; e_i16 = '0; e_h16 = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    chk("R1 rdy8", {15'd0, rdy8}, 16'd1);
    chk("R1 rdy16", {15'd0, rdy16}, 16'd1);
    chk("R1 irq", {14'd0, irq8, irq16}, 16'd0);
    for (int a = 0; a < 4; a++) begin
      ctl_rd(2'(a), a8, a16);
      chk("R1 reg8", a8, (a == 3) ? 16'h8000 : 16'h0000);
      chk("R1 reg16", a16, (a == 3) ? 16'h8000 : 16'h0000);
    end

    // R2/R4/R7 16-bit sweep
    for (int i = 0; i < 8; i++) begin
      logic c;
      w = 16'(i * 16'h3B1D) ^ 16'h5AC3;
      c = i[0];
      host_wr(2, c, w);
      if (c) e_i16 = w; else e_h16 = w;
      chk("R4 rdy16 low", {15'd0, rdy16}, 16'd0);
      chk("R4 irq16 high", {15'd0, irq16}, 16'd1);
      ctl_rd(c ? 2'd0 : 2'd1, a8, a16);
      chk("R2 word16", a16, w);
      ctl_wr(2'd3, 16'h0000);
      chk("R7 ack16", {14'd0, rdy16, irq16}, 16'b10);
    end

    // R3 8-bit sweep, high byte first
    for (int i = 0; i < 8; i++) begin
      logic c;
      w = 16'(i * 16'h2F47) + 16'h0A91;
      c = i[1];
      host_wr(1, c, {8'h00, w[15:8]});
      chk("R3 rdy8 after first byte", {15'd0, rdy8}, 16'd1);
      host_wr(1, c, {8'h00, w[7:0]});
      chk("R3 rdy8 after second byte", {14'd0, rdy8, irq8}, 16'b01);
      if (c) e_i8 = w; else e_h8 = w;
      ctl_rd(c ? 2'd0 : 2'd1, a8, a16);
      chk("R3 word8", a8, w);
      ctl_wr(2'd3, 16'h0000);
      chk("R7 ack8", {14'd0, rdy8, irq8}, 16'b10);
    end

    // R8 ignore while busy, R12 long busy
    host_wr(1, 1'b0, 16'h00BE);
    host_wr(1, 1'b0, 16'h00EF);
    e_h8 = 16'hBEEF;
    host_wr(1, 1'b0, 16'h0011);
    host_wr(1, 1'b0, 16'h0022);
    host_wr(1, 1'b1, 16'h0033);
    host_wr(1, 1'b1, 16'h0044);
    ctl_rd(2'd1, a8, a16);
    chk("R8 hdata kept", a8, e_h8);
    ctl_rd(2'd0, a8, a16);
    chk("R8 instr kept", a8, e_i8);
    repeat (5000) @(negedge clk);
    chk("R12 still busy", {14'd0, rdy8, irq8}, 16'b01);
    ctl_wr(2'd3, 16'h0000);
    chk("R12 ready after ack", {15'd0, rdy8}, 16'd1);
    host_wr(1, 1'b0, 16'h0012);
    host_wr(1, 1'b0, 16'h0034);
    e_h8 = 16'h1234;
    ctl_rd(2'd1, a8, a16);
    chk("R8 toggle untouched", a8, e_h8);
    ctl_wr(2'd3, 16'h0000);

    // R6 status reads
    ctl_wr(2'd3, 16'h4000);
    host_rd(1, 1'b1, v);
    chk("R6 status8", v, 16'h00C0);
    host_rd(2, 1'b1, v);
    chk("R6 status16", v, 16'hC000);
    chk("R6 no effect", {12'd0, rdy8, irq8, rdy16, irq16}, 16'b1010);
    host_wr(2, 1'b0, 16'h7777);
    e_h16 = 16'h7777;
    host_rd(2, 1'b1, v);
    chk("R6 status16 busy", v, 16'h4000);
    ctl_rd(2'd3, a8, a16);
    chk("R10 ctl status16", a16, 16'h4000);
    chk("R10 ctl status8", a8, 16'hC000);
    ctl_wr(2'd3, 16'h0000);
    host_rd(2, 1'b1, v);
    chk("R6 flag cleared", v, 16'h8000);

    // R5 host data reads
    ctl_wr(2'd2, 16'hA5C3);
    host_rd(1, 1'b0, v);
    chk("R5 read hi byte", v, 16'h00A5);
    chk("R5 rdy8 after first byte", {15'd0, rdy8}, 16'd1);
    host_rd(1, 1'b0, v);
    chk("R5 read lo byte", v, 16'h00C3);
    chk("R4 read completes8", {14'd0, rdy8, irq8}, 16'b01);
    host_rd(2, 1'b0, v);
    chk("R5 read16", v, 16'hA5C3);
    chk("R4 read completes16", {14'd0, rdy16, irq16}, 16'b01);
    ctl_wr(2'd3, 16'h0000);

    // R9 phase change restarts at high byte
    host_wr(1, 1'b0, 16'h0012);
    host_wr(1, 1'b1, 16'h0034);
    chk("R9 rdy8 after phase change", {15'd0, rdy8}, 16'd1);
    host_wr(1, 1'b1, 16'h0056);
    chk("R9 rdy8 low", {15'd0, rdy8}, 16'd0);
    ctl_rd(2'd0, a8, a16);
    chk("R9 instr", a8, 16'h3456);
    ctl_rd(2'd1, a8, a16);
    chk("R9 hdata kept", a8, e_h8);
    ctl_wr(2'd3, 16'h0000);

    // R11 no chip select
    host_wr(0, 1'b0, 16'hDEAD);
    host_wr(0, 1'b1, 16'hBEEF);
    chk("R11 ready kept", {14'd0, rdy8, rdy16}, 16'b11);
    ctl_rd(2'd1, a8, a16);
    chk("R11 hdata16", a16, e_h16);
    chk("R11 hdata8", a8, e_h8);
    ctl_rd(2'd0, a8, a16);
    chk("R11 instr16", a16, e_i16);

    // R10 controller access
    ctl_wr(2'd0, 16'h0F0F);
    ctl_rd(2'd0, a8, a16);
    chk("R10 ctl write8", a8, 16'h0F0F);
    chk("R10 ctl write16", a16, 16'h0F0F);
    ctl_rd(2'd3, a8, a16);
    ctl_rd(2'd3, a8, a16);
    chk("R10 read no side effect", a8, 16'h8000);
    chk("R10 irq untouched", {14'd0, irq8, irq16}, 16'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R12 watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule